// File: doc/BRIEF.md
# Frame-level line wait sequencer

This block steps a display frame through its vertical phases, using whole line periods as its unit of time. A horizontal timing engine pulses `line_done` once at the end of every line period. The sequencer counts these pulses and moves through four phases in a fixed order: vertical sync, a wait before the frame, the active lines, and a wait after the frame. After the last phase it starts again at vertical sync.

The wait before the frame lets the line clock keep running. The wait after the frame holds the line clock still through the `lclk_en` gate. Both waits apply only when the active panel mode is selected. In passive mode the block skips both waits whatever their programmed values are, so any extra line periods come only from the sync width. All settings are copied into the block as a frame begins, so each frame runs on one consistent set of values.

The block has no streaming data path. All of its pins are plain control levels or single-cycle strobes.

Top module: `frame_line_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are `vsync`=0, `pix_en`=0 and `lclk_en`=1. The first frame's vertical sync begins on the first clock edge after reset is released.
- R2: `vsync` is high for `cfg_vsync_w`+1 line periods, counted as `line_done` pulses, and `pix_en` is 0 throughout.
- R3: In active mode (`cfg_active`=1) with a nonzero `cfg_bof_wait` value N, N line periods follow the end of vertical sync. During them `vsync`=0, `pix_en`=0 and `lclk_en`=1. When N is 0, the active lines follow vertical sync directly.
- R4: `pix_en` is high for `cfg_lines`+1 line periods, and `lclk_en` stays 1.
- R5: In active mode with a nonzero `cfg_eof_wait` value M, M line periods follow the last active line. During them `lclk_en`=0, `pix_en`=0 and `vsync`=0. Vertical sync starts only after these M periods.
- R6: In active mode with `cfg_eof_wait`=0, vertical sync starts on the line period right after the last active line.
- R7: In passive mode (`cfg_active`=0), `cfg_bof_wait` and `cfg_eof_wait` have no effect: the phases are vertical sync, then active lines, then vertical sync.
- R8: All settings are captured only on the edge where a frame's vertical sync begins. Changing a setting during a frame has no effect until the next frame.
- R9: Phases change only on clock edges where `line_done` is sampled high. The outputs are registered decodes of the phase and do not change in cycles without a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_done | input | 1 | One-cycle pulse at the end of each line period |
| cfg_active | input | 1 | 1 = active panel mode, 0 = passive panel mode |
| cfg_bof_wait | input | 8 | Line periods to wait before the frame (0 disables) |
| cfg_eof_wait | input | 8 | Line periods to wait after the frame (0 disables) |
| cfg_vsync_w | input | 6 | Vertical sync width minus one, in line periods |
| cfg_lines | input | 10 | Active lines per frame minus one |
| vsync | output | 1 | Frame sync, high during the sync phase |
| lclk_en | output | 1 | Line clock gate, 0 holds the line clock still |
| pix_en | output | 1 | High during the active lines |

## Verification
Every output is a decode of a phase register. A phase step shows on the outputs in the cycle after the clock edge that samples `line_done`. The bench therefore drives its inputs and samples the outputs at the falling edge, one full cycle after each pulse. A setting copied at a frame boundary governs the phase held from that same edge onward. The bench records the settings present at each boundary edge and computes the expected phase from the number of pulses seen since that edge. Idle cycles between pulses are sampled as well, to confirm the outputs hold steady.

// File: rtl/fls_pkg.sv
package fls_pkg;
  typedef enum logic [2:0] {
    PH_LOAD = 3'd0,
    PH_SYNC = 3'd1,
    PH_BOF  = 3'd2,
    PH_ACT  = 3'd3,
    PH_EOF  = 3'd4
  } fls_phase_e;

  function automatic int fls_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/fls_shadow.sv
module fls_shadow #(
  parameter int WAIT_W  = 8,
  parameter int SYNC_W  = 6,
  parameter int LINES_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               in_active,
  input  logic [WAIT_W-1:0]  in_bof,
  input  logic [WAIT_W-1:0]  in_eof,
  input  logic [SYNC_W-1:0]  in_vsw,
  input  logic [LINES_W-1:0] in_lines,
  output logic               sh_active,
  output logic [WAIT_W-1:0]  sh_bof,
  output logic [WAIT_W-1:0]  sh_eof,
  output logic [SYNC_W-1:0]  sh_vsw,
  output logic [LINES_W-1:0] sh_lines
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_active <= 1'b0;
      sh_bof    <= '0;
      sh_eof    <= '0;
      sh_vsw    <= '0;
      sh_lines  <= '0;
    end else if (load) begin
      sh_active <= in_active;
      sh_bof    <= in_bof;
      sh_eof    <= in_eof;
      sh_vsw    <= in_vsw;
      sh_lines  <= in_lines;
    end
  end

  // Settings are frozen for the whole frame (R8)
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({sh_active, sh_bof, sh_eof, sh_vsw, sh_lines}));
endmodule

// File: rtl/fls_line_counter.sv
module fls_line_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  assign last = (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  // Count never runs past the current phase length (R2, R4)
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
endmodule

// File: rtl/fls_phase_fsm.sv
module fls_phase_fsm
  import fls_pkg::*;
#(
  parameter int WAIT_W  = 8,
  parameter int SYNC_W  = 6,
  parameter int LINES_W = 10,
  parameter int CNT_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_done,
  input  logic               last,
  input  logic               sh_active,
  input  logic [WAIT_W-1:0]  sh_bof,
  input  logic [WAIT_W-1:0]  sh_eof,
  input  logic [SYNC_W-1:0]  sh_vsw,
  input  logic [LINES_W-1:0] sh_lines,
  output fls_phase_e         phase,
  output logic [CNT_W-1:0]   limit,
  output logic               tick,
  output logic               clr,
  output logic               load
);
  fls_phase_e phase_nx;
  logic       advance;
  logic       bof_on;
  logic       eof_on;

  assign bof_on  = sh_active && (sh_bof != '0);
  assign eof_on  = sh_active && (sh_eof != '0);
  assign tick    = line_done && (phase != PH_LOAD);
  assign advance = tick && last;
  assign clr     = (phase == PH_LOAD);

  always_comb begin
    case (phase)
      PH_SYNC: limit = CNT_W'(sh_vsw);
      PH_BOF:  limit = CNT_W'(sh_bof) - CNT_W'(1);
      PH_ACT:  limit = CNT_W'(sh_lines);
      PH_EOF:  limit = CNT_W'(sh_eof) - CNT_W'(1);
      default: limit = '0;
    endcase
  end

  always_comb begin
    phase_nx = phase;
    load     = 1'b0;
    case (phase)
      PH_LOAD: begin
        phase_nx = PH_SYNC;
        load     = 1'b1;
      end
      PH_SYNC: if (advance) phase_nx = bof_on ? PH_BOF : PH_ACT;
      PH_BOF:  if (advance) phase_nx = PH_ACT;
      PH_ACT: if (advance) begin
        if (eof_on) begin
          phase_nx = PH_EOF;
        end else begin
          phase_nx = PH_SYNC;
          load     = 1'b1;
        end
      end
      PH_EOF: if (advance) begin
        phase_nx = PH_SYNC;
        load     = 1'b1;
      end
      default: phase_nx = PH_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_LOAD;
    else        phase <= phase_nx;
  end

  // Post-frame wait exists only in active mode with a nonzero count (R7)
  p_eof_active_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EOF) |-> (sh_active && sh_eof != '0));

  // Pre-frame wait exists only in active mode with a nonzero count (R7)
  p_bof_active_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BOF) |-> (sh_active && sh_bof != '0));

  // Sync is reached only from the last line or from the post-frame wait (R5)
  p_sync_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SYNC && $past(phase) != PH_SYNC && $past(phase) != PH_LOAD)
      |-> ($past(phase) == PH_ACT || $past(phase) == PH_EOF));

  // Phase moves only on a sampled line pulse (R9)
  p_step_on_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase) && $past(phase) != PH_LOAD) |-> $past(line_done));
endmodule

// File: rtl/frame_line_seq.sv
module frame_line_seq
  import fls_pkg::*;
#(
  parameter int WAIT_W  = 8,
  parameter int SYNC_W  = 6,
  parameter int LINES_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_done,
  input  logic               cfg_active,
  input  logic [WAIT_W-1:0]  cfg_bof_wait,
  input  logic [WAIT_W-1:0]  cfg_eof_wait,
  input  logic [SYNC_W-1:0]  cfg_vsync_w,
  input  logic [LINES_W-1:0] cfg_lines,
  output logic               vsync,
  output logic               lclk_en,
  output logic               pix_en
);
  localparam int CNT_W = fls_max3(WAIT_W, SYNC_W, LINES_W);

  fls_phase_e         phase;
  logic [CNT_W-1:0]   limit;
  logic               tick;
  logic               clr;
  logic               load;
  logic               last;
  logic               sh_active;
  logic [WAIT_W-1:0]  sh_bof;
  logic [WAIT_W-1:0]  sh_eof;
  logic [SYNC_W-1:0]  sh_vsw;
  logic [LINES_W-1:0] sh_lines;

  fls_shadow #(.WAIT_W(WAIT_W), .SYNC_W(SYNC_W), .LINES_W(LINES_W)) shadow_i (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_active(cfg_active), .in_bof(cfg_bof_wait), .in_eof(cfg_eof_wait),
    .in_vsw(cfg_vsync_w), .in_lines(cfg_lines),
    .sh_active(sh_active), .sh_bof(sh_bof), .sh_eof(sh_eof),
    .sh_vsw(sh_vsw), .sh_lines(sh_lines)
  );

  fls_line_counter #(.CNT_W(CNT_W)) counter_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
    .limit(limit), .last(last)
  );

  fls_phase_fsm #(
    .WAIT_W(WAIT_W), .SYNC_W(SYNC_W), .LINES_W(LINES_W), .CNT_W(CNT_W)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .line_done(line_done), .last(last),
    .sh_active(sh_active), .sh_bof(sh_bof), .sh_eof(sh_eof),
    .sh_vsw(sh_vsw), .sh_lines(sh_lines),
    .phase(phase), .limit(limit), .tick(tick), .clr(clr), .load(load)
  );

  assign vsync   = (phase == PH_SYNC);
  assign pix_en  = (phase == PH_ACT);
  assign lclk_en = (phase != PH_EOF);
endmodule

// File: tb/frame_line_seq_tb_top.sv
`timescale 1ns/1ps
module frame_line_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_done;
  logic       cfg_active;
  logic [7:0] cfg_bof_wait;
  logic [7:0] cfg_eof_wait;
  logic [5:0] cfg_vsync_w;
  logic [9:0] cfg_lines;
  logic       vsync, lclk_en, pix_en;

  int checks = 0;
  int fails  = 0;
  int f_vs, f_b, f_a, f_e, pos;
  bit f_act;
  bit mid_change;

  always #2 clk = ~clk;

  frame_line_seq dut_i (
    .clk(clk), .rst_n(rst_n), .line_done(line_done), .cfg_active(cfg_active),
    .cfg_bof_wait(cfg_bof_wait), .cfg_eof_wait(cfg_eof_wait),
    .cfg_vsync_w(cfg_vsync_w), .cfg_lines(cfg_lines),
    .vsync(vsync), .lclk_en(lclk_en), .pix_en(pix_en)
  );

  function automatic int exp_code(input int p);
    if (p < f_vs) return 0;
    if (p < f_vs + f_b) return 1;
    if (p < f_vs + f_b + f_a) return 2;
    return 3;
  endfunction

  task automatic latch_frame();
    f_act = cfg_active;
    f_vs  = int'(cfg_vsync_w) + 1;
    f_b   = cfg_active ? int'(cfg_bof_wait) : 0;
    f_a   = int'(cfg_lines) + 1;
    f_e   = cfg_active ? int'(cfg_eof_wait) : 0;
    pos   = 0;
    mid_change = 1'b0;
  endtask

  task automatic check_outs(input string why);
    int c;
    string tag;
    logic [2:0] expv;
    c = exp_code(pos);
    case (c)
      0: tag = "R2";
      1: tag = "R3";
      2: tag = "R4";
      default: tag = "R5";
    endcase
    if (!f_act) tag = "R7";
    if (why != "") tag = why;
    if (mid_change) tag = {tag, "/R8"};
    expv = {c == 0, c == 2, c != 3};
    checks++;
    if ({vsync, pix_en, lclk_en} !== expv) begin
      fails++;
      $display("FAIL %s pos=%0d {vsync,pix_en,lclk_en} got %b exp %b",
               tag, pos, {vsync, pix_en, lclk_en}, expv);
    end
  endtask

  task automatic strobe();
    string why;
    why = "";
    @(negedge clk);
    line_done = 1'b1;
    @(negedge clk);
    line_done = 1'b0;
    pos++;
    if (pos == f_vs + f_b + f_a + f_e) begin
      if (f_act && f_e == 0) why = "R6";
      latch_frame();
    end
    check_outs(why);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_outs("R9");
    end
  endtask

  task automatic run_frame();
    do strobe(); while (pos != 0);
  endtask

  task automatic set_cfg(input bit a, input int b, input int e, input int v, input int l);
    cfg_active   = a;
    cfg_bof_wait = 8'(b);
    cfg_eof_wait = 8'(e);
    cfg_vsync_w  = 6'(v);
    cfg_lines    = 10'(l);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd77);
    rst_n = 1'b0;
    line_done = 1'b0;
    set_cfg(1'b1, 2, 3, 1, 3);
    repeat (3) @(negedge clk);
    line_done = 1'b1;
    @(negedge clk);
    line_done = 1'b0;
    checks++;
    if ({vsync, pix_en, lclk_en} !== 3'b001) begin
      fails++;
      $display("FAIL R1 reset outputs got %b exp 001", {vsync, pix_en, lclk_en});
    end
    rst_n = 1'b1;
    @(negedge clk);
    latch_frame();
    check_outs("R1");

    // Directed: active mode with both waits
    run_frame();
    // Passive mode: nonzero waits must be ignored
    set_cfg(1'b0, 5, 6, 2, 2);
    run_frame();
    run_frame();
    // Active mode, both waits disabled
    set_cfg(1'b1, 0, 0, 0, 1);
    run_frame();
    run_frame();
    // Maximum waits, single line
    set_cfg(1'b1, 255, 255, 63, 0);
    run_frame();
    run_frame();

    // Random frames with mid-frame setting changes
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 9) < 3) begin
        set_cfg(1'($urandom_range(0, 1)), $urandom_range(0, 4), $urandom_range(0, 4),
                $urandom_range(0, 3), $urandom_range(0, 6));
        mid_change = 1'b1;
      end
      idle($urandom_range(0, 2));
      strobe();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule